// File: doc/BRIEF.md
# Iterative Bit Scatter/Gather Unit

This block places or collects bits of a data word under the control of a selector word. In scatter (deposit) mode the low-order bits of the data word are spread, in order, onto the bit positions where the selector holds a one. In gather (extract) mode the data bits sitting under the selector's ones are collected and packed, in order, into the low end of the result. Bits of the result that receive nothing are zero.

The unit is sequential. It captures its operands on a start strobe, then handles one set selector bit per clock, from the least significant upward. Each step isolates the lowest remaining one, routes a single bit, and removes that one from the working selector. Latency therefore follows the selector's population count, and a fully clear selector finishes at once. A host drives `start_i`, waits for the single-cycle `done_o`, and reads `result_o`, which stays valid until the next operation completes.

Top module: `bitscat_unit`

## Requirements
- R1: After synchronous reset, `result_o` is zero and both `done_o` and `busy_o` are low.
- R2: A `start_i` seen while idle captures `data_i`, `sel_i` and `mode_i` at that clock edge; `busy_o` is high from the next cycle, and later changes on those inputs do not affect the running operation.
- R3: With `mode_i` = 0 (scatter), data bit k (counting from bit 0) lands at the position of the k-th lowest one in the selector.
- R4: With `mode_i` = 1 (gather), the data bit under the k-th lowest selector one lands at result bit k.
- R5: Result bits that receive no data bit are zero: in scatter mode every position where the selector is zero, in gather mode every bit at or above the selector's population count.
- R6: An all-zero selector yields a zero result with `done_o` high one cycle after the capturing edge.
- R7: Each busy cycle consumes exactly one selector one, lowest first; `done_o` rises P+1 clock edges after the capturing edge, P being the selector's population count.
- R8: `done_o` is a single-cycle pulse during which `busy_o` is low, and `result_o` holds its value until the next operation completes.
- R9: A `start_i` pulse while the unit is busy is ignored: the running operation's result and completion time are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (honoured only when idle) |
| mode_i | input | 1 | 0 = scatter (deposit), 1 = gather (extract) |
| data_i | input | W | Data word |
| sel_i | input | W | Selector word |
| result_o | output | W | Registered result of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while an operation is in progress |

## Verification
A corrupted working selector shows up twice at the ports: bits land in the wrong place in `result_o`, and `done_o` arrives earlier or later than P+1 edges after the start, so every operation's completion cycle is measured against the population count. A wrong step counter misplaces bits from the first step onward, visible in the result of any operation with two or more selector ones. Operands that leak in while busy would alter the result of the very operation in progress, so inputs are scrambled right after capture and a second start is injected mid-run.

// File: rtl/bitscat_pkg.sv
package bitscat_pkg;
  typedef enum logic {
    BS_SCATTER = 1'b0,
    BS_GATHER  = 1'b1
  } bs_mode_e;
endpackage

// File: rtl/bitscat_lsb_find.sv
module bitscat_lsb_find #(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  sel,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Isolate the lowest one: sel AND two's complement of sel
  assign onehot = sel & (~sel + W'(1));
  assign any    = |sel;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/bitscat_step.sv
module bitscat_step
  import bitscat_pkg::*;
#(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  bs_mode_e      mode,
  input  logic [W-1:0]  data,
  input  logic [W-1:0]  acc,
  input  logic [W-1:0]  onehot,
  input  logic [IW-1:0] pos,
  input  logic [IW-1:0] k,
  output logic [W-1:0]  acc_next
);
  logic [W-1:0] put_scatter;
  logic [W-1:0] put_gather;

  // scatter: data bit k goes to the isolated position
  assign put_scatter = data[k] ? onehot : '0;
  // gather: data bit at the isolated position goes to bit k
  assign put_gather  = W'(data[pos]) << k;

  always_comb begin
    if (mode == BS_SCATTER) acc_next = acc | put_scatter;
    else                    acc_next = acc | put_gather;
  end
endmodule

// File: rtl/bitscat_unit.sv
module bitscat_unit
  import bitscat_pkg::*;
#(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] result_o,
  output logic         done_o,
  output logic         busy_o
);
  logic [W-1:0]  data_q;
  logic [W-1:0]  sel_q;
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  bs_mode_e      mode_q;
  logic          busy_q;

  logic [W-1:0]  low_onehot;
  logic [IW-1:0] low_idx;
  logic          sel_any;
  logic [W-1:0]  acc_nxt;

  bitscat_lsb_find #(.W(W)) u_find (
    .sel    (sel_q),
    .onehot (low_onehot),
    .idx    (low_idx),
    .any    (sel_any)
  );

  bitscat_step #(.W(W)) u_step (
    .mode     (mode_q),
    .data     (data_q),
    .acc      (acc_q),
    .onehot   (low_onehot),
    .pos      (low_idx),
    .k        (cnt_q[IW-1:0]),
    .acc_next (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      sel_q    <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      mode_q   <= BS_SCATTER;
      busy_q   <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          data_q <= data_i;
          sel_q  <= sel_i;
          mode_q <= bs_mode_e'(mode_i);
          acc_q  <= '0;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else if (sel_any) begin
        acc_q <= acc_nxt;
        sel_q <= sel_q & (sel_q - W'(1));
        cnt_q <= cnt_q + CW'(1);
      end else begin
        result_o <= acc_q;
        done_o   <= 1'b1;
        busy_q   <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;

  // Each working step removes exactly one selector bit
  assert_one_bit_per_step_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && sel_any) |=> ($countones(sel_q) + 1 == $countones($past(sel_q))));

  // Isolated lowest bit is a single bit, present whenever selector is nonzero
  assert_lowest_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ($onehot0(low_onehot) && (sel_any == (low_onehot != '0))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // Operands frozen while busy
  assert_operands_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(data_q) && $stable(mode_q)));

  // Gather result is packed below the count of consumed bits
  assert_gather_packed_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == BS_GATHER) |-> ((result_o >> cnt_q) == '0));
endmodule

// File: tb/bitscat_unit_tb.sv
module bitscat_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic         mode_i;
  logic [W-1:0] data_i;
  logic [W-1:0] sel_i;
  logic [W-1:0] result_o;
  logic         done_o;
  logic         busy_o;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  bitscat_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .data_i(data_i), .sel_i(sel_i), .result_o(result_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  function automatic logic [W-1:0] ref_scatter(input logic [W-1:0] d, input logic [W-1:0] s);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (s[i]) begin r[i] = d[k]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_gather(input logic [W-1:0] d, input logic [W-1:0] s);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (s[i]) begin r[k] = d[i]; k++; end
    return r;
  endfunction

  function automatic int popc(input logic [W-1:0] s);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(s[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; scrambles inputs after capture (R2); returns result and latency in edges
  task automatic run_op(input logic [W-1:0] d, input logic [W-1:0] s, input logic md,
                        output logic [W-1:0] r, output int lat);
    int n;
    @(negedge clk);
    data_i = d; sel_i = s; mode_i = md; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; data_i = ~d; sel_i = ~s; mode_i = ~md;
    n = 1;
    check(busy_o === 1'b1, "R2 busy after capture", W'(busy_o), W'(1));
    while (!done_o && n < 200) begin @(negedge clk); n++; end
    r = result_o;
    lat = n - 1;
  endtask

  task automatic t_reset;
    rst = 1'b1; start_i = 1'b0; mode_i = 1'b0; data_i = '0; sel_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(result_o == '0, "R1 result after reset", result_o, '0);
    check(done_o == 1'b0 && busy_o == 1'b0, "R1 flags after reset",
          W'({done_o, busy_o}), '0);
  endtask

  task automatic t_one(input logic [W-1:0] d, input logic [W-1:0] s, input logic md, input string tag);
    logic [W-1:0] r, e;
    int lat;
    run_op(d, s, md, r, lat);
    e = md ? ref_gather(d, s) : ref_scatter(d, s);
    check(r == e, tag, r, e);
    check(lat == popc(s) + 1, "R7 latency", W'(lat), W'(popc(s) + 1));
    if (md) check((popc(s) == W) || ((r >> popc(s)) == '0), "R5 gather upper zero", r, '0);
    else    check((r & ~s) == '0, "R5 scatter outside selector zero", r & ~s, '0);
  endtask

  task automatic t_scatter_directed;
    t_one(32'h0000_00A5, 32'hF0F0_0000, 1'b0, "R3 scatter nibbles");
    t_one(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R3 scatter ends");
    t_one(32'h1234_5678, 32'hFFFF_FFFF, 1'b0, "R3 scatter full selector");
    t_one(32'h0000_0002, 32'h0000_0300, 1'b0, "R3 scatter second bit");
  endtask

  task automatic t_gather_directed;
    t_one(32'hDEAD_BEEF, 32'hFF00_0000, 1'b1, "R4 gather top byte");
    t_one(32'h8000_0001, 32'h8000_0001, 1'b1, "R4 gather ends");
    t_one(32'hCAFE_F00D, 32'hFFFF_FFFF, 1'b1, "R4 gather full selector");
    t_one(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R4 gather alternating");
  endtask

  task automatic t_zero_sel;
    logic [W-1:0] r;
    int lat;
    run_op(32'hFFFF_FFFF, '0, 1'b0, r, lat);
    check(r == '0, "R6 zero selector scatter result", r, '0);
    check(lat == 1, "R6 zero selector latency", W'(lat), W'(1));
    run_op(32'hFFFF_FFFF, '0, 1'b1, r, lat);
    check(r == '0, "R6 zero selector gather result", r, '0);
  endtask

  task automatic t_hold;
    logic [W-1:0] r;
    int lat;
    run_op(32'h0000_000F, 32'h0F00_0000, 1'b0, r, lat);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single pulse", W'(done_o), '0);
    repeat (3) @(negedge clk);
    check(result_o == 32'h0F00_0000, "R8 result held", result_o, 32'h0F00_0000);
  endtask

  task automatic t_busy_start;
    int n;
    logic [W-1:0] e;
    e = ref_gather(32'h0F0F_0F0F, 32'h00FF_00FF);
    @(negedge clk);
    data_i = 32'h0F0F_0F0F; sel_i = 32'h00FF_00FF; mode_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; n = 1;
    repeat (2) begin @(negedge clk); n++; end
    data_i = '1; sel_i = 32'h0000_0001; mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk); n++;
    start_i = 1'b0;
    while (!done_o && n < 200) begin @(negedge clk); n++; end
    check(result_o == e, "R9 start while busy ignored (result)", result_o, e);
    check(n - 1 == 17, "R9 start while busy ignored (latency)", W'(n - 1), W'(17));
    @(negedge clk);
    check(busy_o == 1'b0, "R9 no extra operation launched", W'(busy_o), '0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 120; i++) begin
      logic [W-1:0] d, s;
      d = $urandom();
      s = $urandom();
      if (i % 4 == 1) s = s & $urandom();
      if (i % 4 == 2) s = s | $urandom();
      t_one(d, s, i[0], (i[0] ? "R4 gather random" : "R3 scatter random"));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(7));
    t_reset();
    t_scatter_directed();
    t_gather_directed();
    t_zero_sel();
    t_hold();
    t_busy_start();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule